// File: doc/BRIEF.md
# Instruction Compressibility Classifier

This block takes one pre-decoded instruction descriptor per transfer and reports the shortest encoding kind the instruction could use in a compressed instruction stream. The descriptor gives an operation class, three register numbers (target, first source, second source), each with a floating-point tag, the bit length of an immediate or offset, a condition-register field number and a width bit. The block does not look at neighbouring instructions. A sequencer that plans mode switches across a stream uses the kind it returns.

The decision has two parts. The first is whether each register falls into one of two small remapped subsets, one reachable with a 3-bit field and one with a 2-bit field. The second is a set of operand-equality rules that differ for each operation class. The decision logic is combinational. A single output register behind a valid/ready pair holds the result until the consumer takes it.

Top module: `insn_compress_classifier`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A descriptor accepted on a clock edge (`in_valid` and `in_ready` both high) produces its kind on `out_kind` with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_kind` stays unchanged. Kind encoding: 0 uncompressed, 1 compressed-mode 16-bit, 2 compressed-mode immediate form (reserved, never produced by these rules), 3 10-bit.
- R3: Register subsets. The 3-bit set is registers 0 to 7 plus the highest register (31 at the default width). The 2-bit set is registers 2 to 5. Class codes on `in_opc`: 0 unlisted, 1 ori/addi, 2 add, 3 subtract-from, 4 compare, 5 and, 6 nand, 7 or, 8 nor, 9 xor, 10 eqv, 11 indexed store, 12 offset store, 13 indexed load, 14 offset load, 15 float/integer convert.
- R4: Add (class 2). All three registers must be integer registers in the 3-bit set. The result is kind 3 when the target equals either source. Otherwise it is kind 1, except that both sources equal to 0 gives kind 0.
- R5: Subtract-from (class 3). All three registers must be integer registers in the 3-bit set. The result is kind 3 when the target equals the first source, and kind 1 otherwise.
- R6: Compare (class 4). Both compared sources must be integer registers in the 3-bit set. The result is kind 3 only when `in_crf` is 0 and `in_wide` is 1, and kind 1 otherwise.
- R7: And, nand and or (classes 5 to 7) and nor (class 8). All registers must be integer registers in the 3-bit set, and the first source must not be 0. The result is kind 3 when the target equals the second source, except for nor. All other qualifying cases are kind 1.
- R8: Xor and eqv (classes 9, 10) follow the constraints of R7 but only ever give kind 1.
- R9: Store (classes 11, 12). The address registers are the first and second sources. An offset store uses 0 as the second address register and `in_imm_len` must be 0. The result is kind 3 when one address register is 0 and the other is in the 2-bit set. It is kind 1 when one is in the 2-bit set and the other is in the 3-bit set. Any other case is kind 0. The data register is ignored.
- R10: Load (classes 13, 14). Both address registers must be integer registers in the 3-bit set. An offset load uses 0 as the second address register and needs `in_imm_len` equal to 0. The result is kind 3 when the target equals an address register, and kind 1 otherwise.
- R11: Class 1 is a nop, kind 3, only when the target and first source are integer register 0 and `in_imm_len` is 0. Any other class 1 descriptor is kind 0.
- R12: Convert (class 15). The target and first source must be floating-point registers in the 2-bit set. The result is then kind 1, and kind 0 otherwise. It is never kind 3.
- R13: Class 0, a register outside the required subset, or a wrong register tag gives kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted this cycle when high with in_valid |
| in_opc | input | 4 | Operation class code |
| in_rd | input | REG_W (5) | Target register number |
| in_rd_fp | input | 1 | Target is a floating-point register |
| in_rs1 | input | REG_W (5) | First source / first address register |
| in_rs1_fp | input | 1 | First source is a floating-point register |
| in_rs2 | input | REG_W (5) | Second source / second address register |
| in_rs2_fp | input | 1 | Second source is a floating-point register |
| in_imm_len | input | IMM_LEN_W (7) | Bit length of the immediate or offset (0 means value zero) |
| in_crf | input | CRF_W (3) | Condition-register field of a compare |
| in_wide | input | 1 | Compare width bit |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | Encoding kind |

## Verification
The bench builds the block with its defaults: a 5-bit register number, so register 31 is the top register and the only high member of the 3-bit set, and registers 8 to 30 all fall outside it. The immediate length field is 7 bits wide. With these values a small set of register numbers reaches every edge of both subsets: 0, 1, 2, 5, 6, 7, 8, 9 and 31. Offset zero versus a non-zero length is also reachable. The stall case holds the output across several cycles with a second descriptor waiting, which covers both sides of the ready equation.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    KIND_FULL = 2'd0,
    KIND_C16  = 2'd1,
    KIND_I16  = 2'd2,
    KIND_TEN  = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    OC_OTHER = 4'd0,
    OC_NOPC  = 4'd1,
    OC_ADD   = 4'd2,
    OC_SUBF  = 4'd3,
    OC_CMP   = 4'd4,
    OC_AND   = 4'd5,
    OC_NAND  = 4'd6,
    OC_OR    = 4'd7,
    OC_NOR   = 4'd8,
    OC_XOR   = 4'd9,
    OC_EQV   = 4'd10,
    OC_STX   = 4'd11,
    OC_STO   = 4'd12,
    OC_LDX   = 4'd13,
    OC_LDO   = 4'd14,
    OC_FCVT  = 4'd15
  } opc_e;

  typedef struct packed {
    logic in3;
    logic in2;
    logic zero;
  } regq_t;

  function automatic kind_e pick_kind(input logic ok, input logic ten);
    if (!ok)
      return KIND_FULL;
    return ten ? KIND_TEN : KIND_C16;
  endfunction

endpackage

// File: rtl/cc_reg_sets.sv
module cc_reg_sets
  import cc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [2:0][REG_W-1:0] regs,
  output regq_t [2:0]           q
);
  localparam logic [REG_W-1:0] TOP_REG = '1;
  localparam logic [REG_W-1:0] LIM3    = REG_W'(8);
  localparam logic [REG_W-1:0] LO2     = REG_W'(2);
  localparam logic [REG_W-1:0] HI2     = REG_W'(5);

  for (genvar i = 0; i < 3; i++) begin : g_op
    assign q[i].zero = (regs[i] == '0);
    assign q[i].in3  = (regs[i] < LIM3) || (regs[i] == TOP_REG);
    assign q[i].in2  = (regs[i] >= LO2) && (regs[i] <= HI2);
  end

endmodule

// File: rtl/cc_rules.sv
module cc_rules
  import cc_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int IMM_LEN_W = 7,
  parameter int CRF_W     = 3
) (
  input  logic [3:0]           opc,
  input  logic [REG_W-1:0]     rd,
  input  logic [REG_W-1:0]     rs1,
  input  logic [REG_W-1:0]     rs2,
  input  logic [2:0]           fp,
  input  regq_t [2:0]          q,
  input  logic [IMM_LEN_W-1:0] imm_len,
  input  logic [CRF_W-1:0]     crf,
  input  logic                 wide,
  output kind_e                kind
);
  logic  gpr_all, all3, eq_d1, eq_d2, off_zero, offset_form;
  regq_t addr_b;
  logic  addr_b_gpr, eq_db;
  logic  ok, ten;

  assign gpr_all  = !fp[0] && !fp[1] && !fp[2];
  assign all3     = q[0].in3 && q[1].in3 && q[2].in3;
  assign eq_d1    = (rd == rs1);
  assign eq_d2    = (rd == rs2);
  assign off_zero = (imm_len == '0);

  // offset forms use an implicit register 0 as second address
  assign offset_form = (opc == OC_STO) || (opc == OC_LDO);
  assign addr_b      = offset_form ? regq_t'{in3: 1'b1, in2: 1'b0, zero: 1'b1} : q[2];
  assign addr_b_gpr  = offset_form ? 1'b1 : !fp[2];
  assign eq_db       = offset_form ? (rd == '0) : eq_d2;

  always_comb begin
    ok  = 1'b0;
    ten = 1'b0;
    unique case (opc_e'(opc))
      OC_NOPC: begin
        ok  = q[0].zero && q[1].zero && !fp[0] && !fp[1] && off_zero;
        ten = 1'b1;
      end
      OC_ADD: begin
        ten = eq_d1 || eq_d2;
        ok  = gpr_all && all3 && (ten || !(q[1].zero && q[2].zero));
      end
      OC_SUBF: begin
        ok  = gpr_all && all3;
        ten = eq_d1;
      end
      OC_CMP: begin
        ok  = !fp[1] && !fp[2] && q[1].in3 && q[2].in3;
        ten = (crf == '0) && wide;
      end
      OC_AND, OC_NAND, OC_OR: begin
        ok  = gpr_all && all3 && !q[1].zero;
        ten = eq_d2;
      end
      OC_NOR, OC_XOR, OC_EQV: begin
        ok  = gpr_all && all3 && !q[1].zero;
        ten = 1'b0;
      end
      OC_STX, OC_STO: begin
        ten = (q[1].in2 && addr_b.zero) || (q[1].zero && addr_b.in2);
        ok  = !fp[1] && addr_b_gpr && (!offset_form || off_zero) &&
              (ten || (q[1].in2 && addr_b.in3) || (q[1].in3 && addr_b.in2));
      end
      OC_LDX, OC_LDO: begin
        ok  = !fp[1] && addr_b_gpr && q[1].in3 && addr_b.in3 &&
              (!offset_form || off_zero);
        ten = eq_d1 || eq_db;
      end
      OC_FCVT: begin
        ok  = fp[0] && fp[1] && q[0].in2 && q[1].in2;
        ten = 1'b0;
      end
      default: begin
        ok  = 1'b0;
        ten = 1'b0;
      end
    endcase
    kind = pick_kind(ok, ten);
  end

endmodule

// File: rtl/cc_out_stage.sv
module cc_out_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= in_data;
    end
  end

endmodule

// File: rtl/insn_compress_classifier.sv
module insn_compress_classifier
  import cc_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int IMM_LEN_W = 7,
  parameter int CRF_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0]           in_opc,
  input  logic [REG_W-1:0]     in_rd,
  input  logic                 in_rd_fp,
  input  logic [REG_W-1:0]     in_rs1,
  input  logic                 in_rs1_fp,
  input  logic [REG_W-1:0]     in_rs2,
  input  logic                 in_rs2_fp,
  input  logic [IMM_LEN_W-1:0] in_imm_len,
  input  logic [CRF_W-1:0]     in_crf,
  input  logic                 in_wide,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind
);
  regq_t [2:0] reg_q;
  kind_e       kind_sel;
  logic [1:0]  kind_next;
  logic        accept;

  cc_reg_sets #(.REG_W(REG_W)) u_sets (
    .regs ({in_rs2, in_rs1, in_rd}),
    .q    (reg_q)
  );

  cc_rules #(.REG_W(REG_W), .IMM_LEN_W(IMM_LEN_W), .CRF_W(CRF_W)) u_rules (
    .opc     (in_opc),
    .rd      (in_rd),
    .rs1     (in_rs1),
    .rs2     (in_rs2),
    .fp      ({in_rs2_fp, in_rs1_fp, in_rd_fp}),
    .q       (reg_q),
    .imm_len (in_imm_len),
    .crf     (in_crf),
    .wide    (in_wide),
    .kind    (kind_sel)
  );

  assign kind_next = kind_sel;
  assign accept    = in_valid && in_ready;

  cc_out_stage #(.W(2)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (kind_next),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_kind)
  );

endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int CRF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [3:0]       in_opc,
  input logic [CRF_W-1:0] in_crf,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [1:0]       kind_next,
  input logic             accept
);
  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && (out_kind == $past(kind_next)));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind));

  // R2
  no_imm_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind_next != 2'd2);

  // R6
  cmp_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_opc == 4'd4 && in_crf != '0 |=> out_kind != 2'd3);

  // R12
  cvt_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_opc == 4'd15 |=> out_kind != 2'd3);

  // R13
  unlisted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_opc == 4'd0 |=> out_kind == 2'd0);

endmodule

bind insn_compress_classifier cc_checker #(.CRF_W(CRF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_opc    (in_opc),
  .in_crf    (in_crf),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_kind  (out_kind),
  .kind_next (kind_next),
  .accept    (accept)
);

// File: tb/sim_insn_compress_classifier.sv
module sim_insn_compress_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_opc = '0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic       in_rd_fp = 1'b0, in_rs1_fp = 1'b0, in_rs2_fp = 1'b0;
  logic [6:0] in_imm_len = '0;
  logic [2:0] in_crf = '0;
  logic       in_wide = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_kind;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  insn_compress_classifier u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc(in_opc), .in_rd(in_rd), .in_rd_fp(in_rd_fp),
    .in_rs1(in_rs1), .in_rs1_fp(in_rs1_fp), .in_rs2(in_rs2), .in_rs2_fp(in_rs2_fp),
    .in_imm_len(in_imm_len), .in_crf(in_crf), .in_wide(in_wide),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int opc, input int rd, input bit rdf, input int a, input bit af,
                     input int b, input bit bf, input int len, input int crf, input bit w);
    in_opc = 4'(opc); in_rd = 5'(rd); in_rd_fp = rdf;
    in_rs1 = 5'(a); in_rs1_fp = af; in_rs2 = 5'(b); in_rs2_fp = bf;
    in_imm_len = 7'(len); in_crf = 3'(crf); in_wide = w;
  endtask

  // one descriptor through; result sampled at the negedge after capture
  task automatic run(input string req, input int opc, input int rd, input bit rdf,
                     input int a, input bit af, input int b, input bit bf,
                     input int len, input int crf, input bit w, input int exp);
    @(negedge clk);
    put(opc, rd, rdf, a, af, b, bf, len, crf, w);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk(req, int'(out_kind), exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_add();
    run("R4 add rd=rs1", 2, 3, 0, 3, 0, 31, 0, 0, 0, 0, 3);
    run("R4 add distinct", 2, 1, 0, 2, 0, 4, 0, 0, 0, 0, 1);
    run("R4 add both src r0", 2, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run("R4 add rd=src=r0", 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    run("R3 add r8 outside", 2, 8, 0, 1, 0, 2, 0, 0, 0, 0, 0);
    run("R13 add fp tag", 2, 1, 0, 2, 0, 4, 1, 0, 0, 0, 0);
  endtask

  task automatic t_subf();
    run("R5 subf rd=rs1", 3, 2, 0, 2, 0, 7, 0, 0, 0, 0, 3);
    run("R5 subf rd=rs2", 3, 2, 0, 7, 0, 2, 0, 0, 0, 0, 1);
    run("R5 subf r9", 3, 2, 0, 9, 0, 2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_cmp();
    run("R6 cmp cr0 wide", 4, 0, 0, 1, 0, 31, 0, 0, 0, 1, 3);
    run("R6 cmp cr2", 4, 0, 0, 1, 0, 31, 0, 0, 2, 1, 1);
    run("R6 cmp narrow", 4, 0, 0, 1, 0, 31, 0, 0, 0, 0, 1);
    run("R6 cmp r12", 4, 0, 0, 12, 0, 31, 0, 0, 0, 1, 0);
  endtask

  task automatic t_logic();
    run("R7 and rd=rs2", 5, 4, 0, 1, 0, 4, 0, 0, 0, 0, 3);
    run("R7 nor rd=rs2", 8, 4, 0, 1, 0, 4, 0, 0, 0, 0, 1);
    run("R7 or rs1 zero", 7, 4, 0, 0, 0, 4, 0, 0, 0, 0, 0);
    run("R7 nand distinct", 6, 4, 0, 1, 0, 5, 0, 0, 0, 0, 1);
    run("R8 xor rd=rs2", 9, 4, 0, 1, 0, 4, 0, 0, 0, 0, 1);
    run("R8 eqv rs1 zero", 10, 2, 0, 0, 0, 3, 0, 0, 0, 0, 0);
  endtask

  task automatic t_store();
    run("R9 stx a2 b0", 11, 9, 0, 3, 0, 0, 0, 0, 0, 0, 3);
    run("R9 stx a0 b2", 11, 9, 0, 0, 0, 5, 0, 0, 0, 0, 3);
    run("R9 stx a2 b3", 11, 9, 0, 2, 0, 31, 0, 0, 0, 0, 1);
    run("R9 stx a3 b3", 11, 9, 0, 7, 0, 31, 0, 0, 0, 0, 0);
    run("R9 stx a3 b0", 11, 9, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    run("R9 st offset0", 12, 20, 1, 4, 0, 30, 0, 0, 0, 0, 3);
    run("R9 st offset nz", 12, 20, 1, 4, 0, 30, 0, 3, 0, 0, 0);
  endtask

  task automatic t_load();
    run("R10 ldx rd=a", 13, 3, 0, 3, 0, 6, 0, 0, 0, 0, 3);
    run("R10 ldx distinct", 13, 9, 0, 1, 0, 2, 0, 0, 0, 0, 1);
    run("R10 ldx r8", 13, 9, 0, 1, 0, 8, 0, 0, 0, 0, 0);
    run("R10 ld rd=r0", 14, 0, 0, 5, 0, 17, 0, 0, 0, 0, 3);
    run("R10 ld distinct", 14, 4, 0, 5, 0, 17, 0, 0, 0, 0, 1);
    run("R10 ld offset nz", 14, 4, 0, 5, 0, 17, 0, 2, 0, 0, 0);
  endtask

  task automatic t_nop_cvt_other();
    run("R11 nop", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    run("R11 imm nz", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    run("R11 rd r1", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run("R12 cvt 2set", 15, 2, 1, 5, 1, 0, 0, 0, 0, 0, 1);
    run("R12 cvt r6", 15, 6, 1, 5, 1, 0, 0, 0, 0, 0, 0);
    run("R12 cvt gpr", 15, 2, 0, 5, 0, 0, 0, 0, 0, 0, 0);
    run("R13 unlisted", 0, 3, 0, 3, 0, 3, 0, 0, 0, 1, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    put(2, 3, 0, 3, 0, 31, 0, 0, 0, 0);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 stall first kind", int'(out_kind), 3);
    put(3, 2, 0, 7, 0, 2, 0, 0, 0, 0);
    #0;
    chk("R2 stall in_ready low", int'(in_ready), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 stall hold", int'(out_kind), 3);
      chk("R2 stall valid", int'(out_valid), 1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second kind", int'(out_kind), 1);
    chk("R2 second valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R2 drained", int'(out_valid), 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_subf();
    t_cmp();
    t_logic();
    t_store();
    t_load();
    t_nop_cvt_other();
    t_stall();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule